// File: doc/BRIEF.md
# SATA Port Software-Reset Sequencer

This block is the per-port control state machine of a SATA host adapter. It watches every host-to-device register FIS that the port sends. When the control byte asks for a soft reset and then releases it, the block moves the port through a two-step reset. Along the way it maintains the port's command-issue bitmap, the task-file data register and the device signature register. Host software marks slots as issued through a write strobe. The block records which slot holds the command currently executing. A full port reset can also be requested directly.

The set step of a soft reset produces no answer from the device. Because of that, the block clears the issuing slot itself, but only when the command header carries the clear-busy option. The release step performs a full port reset. After any reset, the first device-ready pulse stands for the initial device-to-host register FIS. That pulse loads the signature and the status, and sets a flag so that later pulses leave both registers alone.

Top module: `sata_srst_seq`

## Requirements
- R1: After rst_n, or one cycle after port_rst_req, the outputs hold these values: cmd_issue=0, tf_data=0x007F, port_sig=0xFFFFFFFF, init_d2h_done=0, busy_valid=0, in_reset=0, d2h_emit=0. A port reset overrides every other input in the same cycle, including dev_ready.
- R2: A FIS is acted on only when fis_valid is high and byte 0 equals 0x27. Byte i of the FIS is fis_data[8*i+7:8*i]. A FIS of any other type changes nothing.
- R3: When issue_wr is high, issue_mask is ORed into cmd_issue on the next edge.
- R4: In the run state, a FIS with the command flag set (byte 1 bit 7) sets busy_valid and copies fis_slot into busy_slot. In the reset state, such a FIS is ignored.
- R5: In the run state, a control FIS (byte 1 bit 7 clear) with the soft-reset bit (byte 15 bit 2) set moves the port to the reset state (in_reset=1). If fis_clr_busy is set, it also clears cmd_issue[fis_slot], and it clears busy_valid when busy_slot equals fis_slot. When issue_wr sets the same bit in the same cycle, the clear wins.
- R6: When the set step arrives with fis_clr_busy low, cmd_issue and the busy record stay as they were.
- R7: In the reset state, a control FIS with the soft-reset bit clear performs the R1 port reset and returns the port to run. A control FIS with the bit set has no effect in the reset state. A control FIS with the bit clear has no effect in the run state.
- R8: The first dev_ready after a reset does all of the following on the next edge: it loads port_sig with {dev_cyl_hi, dev_cyl_lo, dev_lba_lo, dev_nsect} (bits 31:24 down to 7:0), loads tf_data with {dev_error, dev_status}, sets init_d2h_done, and pulses d2h_emit for one cycle. It leaves cmd_issue unchanged.
- R9: dev_ready while init_d2h_done is set changes neither port_sig nor tf_data, and raises no d2h_emit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| issue_wr | input | 1 | Command-issue set strobe |
| issue_mask | input | 32 | Slots to mark issued |
| fis_valid | input | 1 | Host-to-device FIS present this cycle |
| fis_data | input | 160 | FIS bytes, byte 0 in the low bits |
| fis_slot | input | 5 | Command slot carrying the FIS |
| fis_clr_busy | input | 1 | Header option: clear busy on receive-ok |
| port_rst_req | input | 1 | Full port reset request |
| dev_ready | input | 1 | Device sends its register FIS |
| dev_status | input | 8 | Status byte of that FIS |
| dev_error | input | 8 | Error byte of that FIS |
| dev_cyl_hi | input | 8 | Cylinder-high byte |
| dev_cyl_lo | input | 8 | Cylinder-low byte |
| dev_lba_lo | input | 8 | LBA-low byte |
| dev_nsect | input | 8 | Sector-count byte |
| cmd_issue | output | 32 | Command-issue bitmap |
| tf_data | output | 16 | Task-file data {error, status} |
| port_sig | output | 32 | Device signature |
| init_d2h_done | output | 1 | Initial device FIS received since reset |
| d2h_emit | output | 1 | One-cycle pulse on the initial device FIS |
| in_reset | output | 1 | Port in soft-reset state |
| busy_valid | output | 1 | A slot is recorded busy |
| busy_slot | output | 5 | Busy slot number |

## Verification
A wrong state bit shows at the ports one cycle later. A port stuck in reset drops later command FISes, so busy_valid fails to rise. A port that falsely leaves reset wipes cmd_issue early. A stale initial-FIS flag shows when a new signature is missing after a reset, or when a later dev_ready overwrites the signature. A bitmap clear aimed at the wrong slot leaves a set bit visible in cmd_issue on the very next cycle. Every register output is compared one cycle after each stimulus, so each of these faults surfaces within a single step.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
   typedef enum logic {
      ST_RUN = 1'b0,
      ST_RST = 1'b1
   } port_st_e;

   localparam logic [7:0] FIS_TYPE_REG_H2D = 8'h27;

   typedef struct packed {
      logic reg_h2d;
      logic is_cmd;
      logic srst;
   } fis_info_t;
endpackage

// File: rtl/ssq_fis_decode.sv
module ssq_fis_decode
   import ssq_pkg::*;
#(
   parameter int FIS_BYTES = 20,
   parameter int CTRL_IDX  = 15,
   parameter int SRST_BIT  = 2,
   parameter int CFLAG_BIT = 7
) (
   input  logic [FIS_BYTES*8-1:0] fis_data,
   output fis_info_t              info
);
   localparam int FW = FIS_BYTES * 8;

   generate
      if (CTRL_IDX >= FIS_BYTES) begin : g_bad_ctrl
         $error("control byte index outside the FIS");
      end
      if (SRST_BIT > 7 || CFLAG_BIT > 7) begin : g_bad_bit
         $error("bit position outside a byte");
      end
      if (FW < 16) begin : g_bad_len
         $error("FIS too short");
      end
   endgenerate

   logic [7:0] type_b, flag_b, ctrl_b;

   always_comb begin
      type_b = fis_data[7:0];
      flag_b = fis_data[15:8];
      ctrl_b = fis_data[CTRL_IDX*8 +: 8];
      info.reg_h2d = (type_b == FIS_TYPE_REG_H2D);
      info.is_cmd  = flag_b[CFLAG_BIT];
      info.srst    = ctrl_b[SRST_BIT];
   end
endmodule

// File: rtl/ssq_ctrl_fsm.sv
module ssq_ctrl_fsm
   import ssq_pkg::*;
#(
   parameter int SLOT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fis_valid,
   input  fis_info_t         info,
   input  logic              clr_opt,
   input  logic              port_rst_req,
   output port_st_e          state,
   output logic              wipe,
   output logic              clr_en,
   output logic              busy_set
);
   port_st_e state_q;
   logic accept, ctrl_fis, srst_enter, srst_leave;

   always_comb begin
      accept     = fis_valid && info.reg_h2d;
      ctrl_fis   = accept && !info.is_cmd;
      srst_enter = ctrl_fis && info.srst && (state_q == ST_RUN);
      srst_leave = ctrl_fis && !info.srst && (state_q == ST_RST);
      wipe       = port_rst_req || srst_leave;
      clr_en     = srst_enter && clr_opt && !port_rst_req;
      busy_set   = accept && info.is_cmd && (state_q == ST_RUN) && !port_rst_req;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           state_q <= ST_RUN;
      else if (wipe)        state_q <= ST_RUN;
      else if (srst_enter)  state_q <= ST_RST;
   end

   assign state = state_q;

   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fis_valid && info.reg_h2d && !info.is_cmd && !info.srst && state == ST_RST)
      |=> state == ST_RUN);
   p_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fis_valid && info.reg_h2d && !info.is_cmd && info.srst && state == ST_RUN && !port_rst_req)
      |=> state == ST_RST);
   p_rst_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      port_rst_req |=> state == ST_RUN);
endmodule

// File: rtl/ssq_slot_map.sv
module ssq_slot_map #(
   parameter int NUM_SLOTS  = 32,
   parameter bit CLEAR_WINS = 1'b1,
   localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wipe,
   input  logic                 set_en,
   input  logic [NUM_SLOTS-1:0] set_mask,
   input  logic                 clr_en,
   input  logic [SLOT_W-1:0]    clr_slot,
   output logic [NUM_SLOTS-1:0] map
);
   generate
      if (NUM_SLOTS < 2 || NUM_SLOTS > 32) begin : g_bad_slots
         $error("slot count must lie in 2..32");
      end
   endgenerate

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic hit_clr, hit_set;
      assign hit_clr = clr_en && (clr_slot == SLOT_W'(g));
      assign hit_set = set_en && set_mask[g];
      if (CLEAR_WINS) begin : g_clr_first
         always_ff @(posedge clk) begin
            if (!rst_n || wipe) map[g] <= 1'b0;
            else if (hit_clr)   map[g] <= 1'b0;
            else if (hit_set)   map[g] <= 1'b1;
         end
      end else begin : g_set_first
         always_ff @(posedge clk) begin
            if (!rst_n || wipe) map[g] <= 1'b0;
            else if (hit_set)   map[g] <= 1'b1;
            else if (hit_clr)   map[g] <= 1'b0;
         end
      end
   end

   p_wipe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> map == '0);
   p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !wipe && CLEAR_WINS) |=> !map[$past(clr_slot)]);
   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !wipe && !clr_en) |=> ((map & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/ssq_port_regs.sv
module ssq_port_regs #(
   parameter int          SLOT_W    = 5,
   parameter logic [15:0] TFD_RESET = 16'h007F,
   parameter logic [31:0] SIG_RESET = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wipe,
   input  logic              dev_ready,
   input  logic [7:0]        dev_status,
   input  logic [7:0]        dev_error,
   input  logic [7:0]        dev_cyl_hi,
   input  logic [7:0]        dev_cyl_lo,
   input  logic [7:0]        dev_lba_lo,
   input  logic [7:0]        dev_nsect,
   input  logic              busy_set,
   input  logic              clr_en,
   input  logic [SLOT_W-1:0] fis_slot,
   output logic [15:0]       tf_data,
   output logic [31:0]       port_sig,
   output logic              init_done,
   output logic              emit,
   output logic              busy_v,
   output logic [SLOT_W-1:0] busy_s
);
   logic load;
   assign load = dev_ready && !init_done && !wipe;

   always_ff @(posedge clk) begin
      if (!rst_n || wipe) begin
         tf_data   <= TFD_RESET;
         port_sig  <= SIG_RESET;
         init_done <= 1'b0;
         emit      <= 1'b0;
      end else begin
         emit <= load;
         if (load) begin
            tf_data   <= {dev_error, dev_status};
            port_sig  <= {dev_cyl_hi, dev_cyl_lo, dev_lba_lo, dev_nsect};
            init_done <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || wipe) begin
         busy_v <= 1'b0;
         busy_s <= '0;
      end else if (clr_en && busy_v && busy_s == fis_slot) begin
         busy_v <= 1'b0;
      end else if (busy_set) begin
         busy_v <= 1'b1;
         busy_s <= fis_slot;
      end
   end

   p_sig_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (init_done && !wipe) |=> ($stable(port_sig) && $stable(tf_data)));
   p_emit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> emit);
   p_wipe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> (!init_done && !busy_v && port_sig == SIG_RESET && tf_data == TFD_RESET));
endmodule

// File: rtl/sata_srst_seq.sv
module sata_srst_seq
   import ssq_pkg::*;
#(
   parameter int NUM_SLOTS  = 32,
   parameter int FIS_BYTES  = 20,
   parameter int CTRL_IDX   = 15,
   parameter int SRST_BIT   = 2,
   parameter bit CLEAR_WINS = 1'b1,
   localparam int SLOT_W    = $clog2(NUM_SLOTS),
   localparam int FIS_W     = FIS_BYTES * 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 issue_wr,
   input  logic [NUM_SLOTS-1:0] issue_mask,
   input  logic                 fis_valid,
   input  logic [FIS_W-1:0]     fis_data,
   input  logic [SLOT_W-1:0]    fis_slot,
   input  logic                 fis_clr_busy,
   input  logic                 port_rst_req,
   input  logic                 dev_ready,
   input  logic [7:0]           dev_status,
   input  logic [7:0]           dev_error,
   input  logic [7:0]           dev_cyl_hi,
   input  logic [7:0]           dev_cyl_lo,
   input  logic [7:0]           dev_lba_lo,
   input  logic [7:0]           dev_nsect,
   output logic [NUM_SLOTS-1:0] cmd_issue,
   output logic [15:0]          tf_data,
   output logic [31:0]          port_sig,
   output logic                 init_d2h_done,
   output logic                 d2h_emit,
   output logic                 in_reset,
   output logic                 busy_valid,
   output logic [SLOT_W-1:0]    busy_slot
);
   fis_info_t info;
   port_st_e  state;
   logic      wipe, clr_en, busy_set;

   ssq_fis_decode #(
      .FIS_BYTES(FIS_BYTES), .CTRL_IDX(CTRL_IDX), .SRST_BIT(SRST_BIT), .CFLAG_BIT(7)
   ) u_dec (
      .fis_data(fis_data), .info(info)
   );

   ssq_ctrl_fsm #(.SLOT_W(SLOT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .fis_valid(fis_valid), .info(info),
      .clr_opt(fis_clr_busy), .port_rst_req(port_rst_req), .state(state),
      .wipe(wipe), .clr_en(clr_en), .busy_set(busy_set)
   );

   ssq_slot_map #(.NUM_SLOTS(NUM_SLOTS), .CLEAR_WINS(CLEAR_WINS)) u_map (
      .clk(clk), .rst_n(rst_n), .wipe(wipe), .set_en(issue_wr && !port_rst_req),
      .set_mask(issue_mask), .clr_en(clr_en), .clr_slot(fis_slot), .map(cmd_issue)
   );

   ssq_port_regs #(.SLOT_W(SLOT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wipe(wipe), .dev_ready(dev_ready),
      .dev_status(dev_status), .dev_error(dev_error), .dev_cyl_hi(dev_cyl_hi),
      .dev_cyl_lo(dev_cyl_lo), .dev_lba_lo(dev_lba_lo), .dev_nsect(dev_nsect),
      .busy_set(busy_set), .clr_en(clr_en), .fis_slot(fis_slot),
      .tf_data(tf_data), .port_sig(port_sig), .init_done(init_d2h_done),
      .emit(d2h_emit), .busy_v(busy_valid), .busy_s(busy_slot)
   );

   assign in_reset = (state == ST_RST);

   p_no_clear_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fis_valid && !fis_clr_busy && !port_rst_req && !issue_wr && !in_reset)
      |=> cmd_issue == $past(cmd_issue));
   p_emit_ci_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ready && !fis_valid && !issue_wr && !port_rst_req) |=> $stable(cmd_issue));
endmodule

// File: tb/tb_sata_srst_seq.sv
module tb_sata_srst_seq;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic         rst_n, issue_wr, fis_valid, fis_clr_busy, port_rst_req, dev_ready;
   logic [31:0]  issue_mask;
   logic [159:0] fis_data;
   logic [4:0]   fis_slot;
   logic [7:0]   dev_status, dev_error, dev_cyl_hi, dev_cyl_lo, dev_lba_lo, dev_nsect;
   logic [31:0]  cmd_issue, port_sig;
   logic [15:0]  tf_data;
   logic         init_d2h_done, d2h_emit, in_reset, busy_valid;
   logic [4:0]   busy_slot;

   sata_srst_seq dut (
      .clk(clk), .rst_n(rst_n), .issue_wr(issue_wr), .issue_mask(issue_mask),
      .fis_valid(fis_valid), .fis_data(fis_data), .fis_slot(fis_slot),
      .fis_clr_busy(fis_clr_busy), .port_rst_req(port_rst_req), .dev_ready(dev_ready),
      .dev_status(dev_status), .dev_error(dev_error), .dev_cyl_hi(dev_cyl_hi),
      .dev_cyl_lo(dev_cyl_lo), .dev_lba_lo(dev_lba_lo), .dev_nsect(dev_nsect),
      .cmd_issue(cmd_issue), .tf_data(tf_data), .port_sig(port_sig),
      .init_d2h_done(init_d2h_done), .d2h_emit(d2h_emit), .in_reset(in_reset),
      .busy_valid(busy_valid), .busy_slot(busy_slot)
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // op: 1 issue, 2 command FIS, 3 control SRST=1, 4 control SRST=0, 5 port reset, 6 non-register FIS
   typedef struct packed {
      logic [3:0]  req;
      logic [2:0]  op;
      logic [4:0]  slot;
      logic        opt;
      logic [31:0] mask;
      logic [31:0] exp_ci;
      logic        exp_rst;
      logic        exp_bv;
      logic [4:0]  exp_bs;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{4'd3, 3'd1, 5'd0,  1'b0, 32'h0000_0012, 32'h0000_0012, 1'b0, 1'b0, 5'd0},  // R3
      '{4'd4, 3'd2, 5'd4,  1'b0, 32'h0,         32'h0000_0012, 1'b0, 1'b1, 5'd4},  // R4
      '{4'd5, 3'd3, 5'd4,  1'b1, 32'h0,         32'h0000_0002, 1'b1, 1'b0, 5'd0},  // R5
      '{4'd4, 3'd2, 5'd1,  1'b0, 32'h0,         32'h0000_0002, 1'b1, 1'b0, 5'd0},  // R4 ignored in reset
      '{4'd7, 3'd3, 5'd1,  1'b1, 32'h0,         32'h0000_0002, 1'b1, 1'b0, 5'd0},  // R7 set again in reset
      '{4'd7, 3'd4, 5'd0,  1'b0, 32'h0,         32'h0,         1'b0, 1'b0, 5'd0},  // R7 release
      '{4'd3, 3'd1, 5'd0,  1'b0, 32'h8000_0001, 32'h8000_0001, 1'b0, 1'b0, 5'd0},  // R3
      '{4'd4, 3'd2, 5'd31, 1'b0, 32'h0,         32'h8000_0001, 1'b0, 1'b1, 5'd31}, // R4
      '{4'd6, 3'd3, 5'd31, 1'b0, 32'h0,         32'h8000_0001, 1'b1, 1'b1, 5'd31}, // R6
      '{4'd7, 3'd4, 5'd0,  1'b0, 32'h0,         32'h0,         1'b0, 1'b0, 5'd0},  // R7
      '{4'd3, 3'd1, 5'd0,  1'b0, 32'h0000_0004, 32'h0000_0004, 1'b0, 1'b0, 5'd0},  // R3
      '{4'd7, 3'd4, 5'd0,  1'b0, 32'h0,         32'h0000_0004, 1'b0, 1'b0, 5'd0},  // R7 release in run
      '{4'd2, 3'd6, 5'd2,  1'b1, 32'h0,         32'h0000_0004, 1'b0, 1'b0, 5'd0},  // R2
      '{4'd1, 3'd5, 5'd0,  1'b0, 32'h0,         32'h0,         1'b0, 1'b0, 5'd0}   // R1
   };

   function automatic logic [159:0] mk_fis(input logic [7:0] ftype, input logic cflag,
                                           input logic srst);
      logic [159:0] f = '0;
      f[7:0]     = ftype;
      f[15]      = cflag;
      f[16 +: 8] = cflag ? 8'h25 : 8'h00;
      f[122]     = srst;
      return f;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      issue_wr = 0; issue_mask = '0; fis_valid = 0; fis_data = '0; fis_slot = '0;
      fis_clr_busy = 0; port_rst_req = 0; dev_ready = 0;
   endtask

   task automatic set_dev(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] lba,
                          input logic [7:0] ns, input logic [7:0] st, input logic [7:0] er);
      dev_cyl_hi = hi; dev_cyl_lo = lo; dev_lba_lo = lba; dev_nsect = ns;
      dev_status = st; dev_error = er;
   endtask

   // drive one pulse at a falling edge, release at the next one (after the sampling edge)
   task automatic drive_op(input logic [2:0] op, input logic [4:0] slot, input logic opt,
                           input logic [31:0] mask);
      @(negedge clk);
      idle_inputs();
      fis_slot = slot; fis_clr_busy = opt;
      case (op)
         3'd1: begin issue_wr = 1; issue_mask = mask; end
         3'd2: begin fis_valid = 1; fis_data = mk_fis(8'h27, 1'b1, 1'b0); end
         3'd3: begin fis_valid = 1; fis_data = mk_fis(8'h27, 1'b0, 1'b1); end
         3'd4: begin fis_valid = 1; fis_data = mk_fis(8'h27, 1'b0, 1'b0); end
         3'd5: port_rst_req = 1;
         3'd6: begin fis_valid = 1; fis_data = mk_fis(8'h34, 1'b0, 1'b1); end
         default: ;
      endcase
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic pulse_ready();
      @(negedge clk);
      idle_inputs();
      dev_ready = 1;
      @(negedge clk);
      idle_inputs();
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin : main
      idle_inputs();
      set_dev(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk("R1", "cmd_issue", cmd_issue, 32'h0);
      chk("R1", "tf_data", {16'h0, tf_data}, 32'h007F);
      chk("R1", "port_sig", port_sig, 32'hFFFF_FFFF);
      chk("R1", "init/busy/reset/emit", {28'h0, init_d2h_done, busy_valid, in_reset, d2h_emit}, 32'h0);

      // R8 first device FIS, command-issue untouched
      drive_op(3'd1, 5'd0, 1'b0, 32'h0000_0010);
      set_dev(8'hEB, 8'h14, 8'h01, 8'h02, 8'h50, 8'h01);
      @(negedge clk);
      dev_ready = 1;
      @(negedge clk);
      dev_ready = 0;
      chk("R8", "port_sig", port_sig, 32'hEB14_0102);
      chk("R8", "tf_data", {16'h0, tf_data}, 32'h0150);
      chk("R8", "init/emit", {30'h0, init_d2h_done, d2h_emit}, 32'h3);
      chk("R8", "cmd_issue", cmd_issue, 32'h0000_0010);
      @(negedge clk);
      chk("R8", "emit one cycle", {31'h0, d2h_emit}, 32'h0);

      // R9 later device FIS ignored
      set_dev(8'h11, 8'h22, 8'h33, 8'h44, 8'h41, 8'h04);
      pulse_ready();
      chk("R9", "port_sig", port_sig, 32'hEB14_0102);
      chk("R9", "tf_data/emit", {15'h0, tf_data, d2h_emit}, {15'h0, 16'h0150, 1'b0});

      // R1 port reset restores everything
      drive_op(3'd5, 5'd0, 1'b0, 32'h0);
      chk("R1", "sig after port reset", port_sig, 32'hFFFF_FFFF);
      chk("R1", "tfd/init/ci", {15'h0, tf_data, init_d2h_done}, {15'h0, 16'h007F, 1'b0});
      chk("R1", "ci after port reset", cmd_issue, 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         drive_op(VEC[i].op, VEC[i].slot, VEC[i].opt, VEC[i].mask);
         chk($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d cmd_issue", i), cmd_issue, VEC[i].exp_ci);
         chk($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d in_reset", i), {31'h0, in_reset}, {31'h0, VEC[i].exp_rst});
         chk($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d busy", i),
             {26'h0, busy_valid, busy_valid ? busy_slot : 5'd0},
             {26'h0, VEC[i].exp_bv, VEC[i].exp_bs});
      end

      // R5 clear wins over a same-cycle set of the same slot
      @(negedge clk);
      idle_inputs();
      issue_wr = 1; issue_mask = 32'h0000_0009;
      fis_valid = 1; fis_data = mk_fis(8'h27, 1'b0, 1'b1); fis_slot = 5'd3; fis_clr_busy = 1;
      @(negedge clk);
      idle_inputs();
      chk("R5", "clear wins", cmd_issue, 32'h0000_0001);
      chk("R5", "in_reset", {31'h0, in_reset}, 32'h1);

      // R7 release clears signature state, then R8 loads a fresh signature
      set_dev(8'h00, 8'h00, 8'h01, 8'h01, 8'h50, 8'h00);
      pulse_ready();
      chk("R8", "sig before release", port_sig, 32'h0000_0101);
      drive_op(3'd4, 5'd0, 1'b0, 32'h0);
      chk("R7", "sig after release", port_sig, 32'hFFFF_FFFF);
      chk("R7", "tfd/init/ci", {15'h0, tf_data, init_d2h_done}, {15'h0, 16'h007F, 1'b0});
      chk("R7", "ci after release", cmd_issue, 32'h0);
      set_dev(8'h96, 8'h69, 8'h22, 8'h33, 8'h50, 8'h01);
      pulse_ready();
      chk("R8", "sig after soft reset", port_sig, 32'h9669_2233);

      // R1 port reset beats dev_ready in the same cycle
      drive_op(3'd5, 5'd0, 1'b0, 32'h0);
      @(negedge clk);
      idle_inputs();
      port_rst_req = 1; dev_ready = 1;
      @(negedge clk);
      idle_inputs();
      chk("R1", "reset beats ready sig", port_sig, 32'hFFFF_FFFF);
      chk("R1", "reset beats ready init", {30'h0, init_d2h_done, d2h_emit}, 32'h0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule